// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block sits behind the four-wire serial pins of a 1024-byte nonvolatile memory. It samples the serial clock, chip select, data input, pause input and protect input with the system clock. It assembles an 8-bit command, an optional 16-bit address and data bytes, and acts on six commands. Reads stream bytes from an internal byte array and continue for as long as the host keeps clocking. Status reads return a small register. Array writes are not carried out here: each accepted data byte, and the final go-ahead, is passed to a separate page-write controller. That controller also loads the array through a write port and reports a busy flag.

A host lowers chip select, shifts a command byte MSB first on rising serial-clock edges, and raises chip select to end the transfer. The pause input freezes a transfer at any bit. Releasing it lets the transfer carry on from the same bit.

Top module: `spimem_slave`

## Requirements
- R1: Serial input is taken on rising `sck` edges while `cs_n` is low and `hold_n` is high, MSB first. The first edge after `cs_n` falls carries bit 7 of the command.
- R2: Command 0x03 followed by a 16-bit address reads the array from the address modulo 1024, since the upper six address bits are ignored. Data leaves on `so` MSB first and changes on falling `sck` edges. The first bit appears after the falling edge that follows the last address bit.
- R3: While a read keeps being clocked, the address advances by one after each byte and wraps from 0x3FF to 0x000.
- R4: Command 0x05 returns the status byte and repeats it for as long as clocks continue. The bit positions are bit0 = busy (the `wip` input), bit1 = write-enable latch, bit2 = protect bit 0, bit3 = protect bit 1 and bit7 = protect-pin enable. The other bits read 0.
- R5: Command 0x06 sets the write-enable latch and 0x04 clears it. Either takes effect only when `cs_n` rises after exactly 8 bits. The latch also clears when `wip` falls.
- R6: For command 0x02 plus an address, each complete data byte gives a one-cycle `wr_valid` with `wr_data`, provided the latch is set and `wip` is 0. `wr_addr` holds the upper six address bits fixed and lets the low 4 bits wrap inside the 16-byte page.
- R7: `wr_commit` pulses once when `cs_n` rises at a byte boundary after at least one reported data byte. It does not pulse for a transfer that ends mid-byte, and there are no events at all while the latch is clear.
- R8: Command 0x01 followed by one byte stores its bits 7, 3 and 2 into the status, then clears the latch. This happens only when `cs_n` rises after exactly 16 bits and the latch is set. It is ignored when `wp_n` is low and bit 7 is already set.
- R9: While `hold_n` is low, `so_oe` is 0 and `sck` edges are ignored. After release the transfer continues at the same bit.
- R10: A read while `wip` is 1 returns 0xFF.
- R11: An unknown command leaves `so_oe` at 0, produces no events and changes no state until `cs_n` rises.
- R12: `so_oe` is 0 whenever `cs_n` is high.
- R13: After reset the latch and status bits are 0, `so_oe` is 0 and no events are reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| wip | input | 1 | Busy flag from the page-write controller |
| arr_we | input | 1 | Array write strobe from the controller |
| arr_waddr | input | 10 | Array write address |
| arr_wdata | input | 8 | Array write data |
| wr_valid | output | 1 | One-cycle pulse per accepted write byte |
| wr_addr | output | 10 | Array address of that byte |
| wr_data | output | 8 | Value of that byte |
| wr_commit | output | 1 | One-cycle go-ahead for the controller |

## Verification
The bench builds the block with its defaults: 1024 bytes, 16-byte pages and a two-stage input synchronizer. At these sizes a full array preload and a read that crosses 0x3FF to 0x000 both fit in a short run. A write that starts two bytes before the end of a page reaches the in-page wrap after only a few bytes. Random reads with random don't-care address bits exercise the address truncation. Directed cases cover the pause input, the busy-time read, commit aborts and status protection.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_RDAT, PH_WDAT, PH_SRD, PH_SWR, PH_DONE, PH_SKIP
  } phase_t;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  localparam int ST_WIP = 0;
  localparam int ST_WEL = 1;
  localparam int ST_BP0 = 2;
  localparam int ST_BP1 = 3;
  localparam int ST_WPEN = 7;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[g]}};
        else     chain <= {chain[STAGES-2:0], din[g]};
      end
      assign lvl[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spimem_array.sv
module spimem_array #(
  parameter int DEPTH = 1024,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spimem_slave.sv
module spimem_slave
  import spimem_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int PAGE = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  input  logic          hold_n,
  input  logic          wp_n,
  output logic          so,
  output logic          so_oe,
  input  logic          wip,
  input  logic          arr_we,
  input  logic [AW-1:0] arr_waddr,
  input  logic [7:0]    arr_wdata,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit
);
  logic [4:0] pins_s;
  logic sck_s, cs_s, si_s, hold_s, wp_s;
  logic sck_d, cs_d, wip_d;

  spimem_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b01010)) u_sync (
    .clk(clk), .rst(rst), .din({sck, cs_n, si, hold_n, wp_n}), .lvl(pins_s)
  );
  assign {sck_s, cs_s, si_s, hold_s, wp_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0; cs_d <= 1'b1; wip_d <= 1'b0;
    end else begin
      sck_d <= sck_s; cs_d <= cs_s; wip_d <= wip;
    end
  end

  logic active, sample, shift, cs_rise, wip_fall;
  assign active   = !cs_s && hold_s;
  assign sample   = active && sck_s && !sck_d;
  assign shift    = active && !sck_s && sck_d;
  assign cs_rise  = cs_s && !cs_d;
  assign wip_fall = !wip && wip_d;

  phase_t        ph;
  logic [2:0]    bcnt;
  logic [7:0]    sr, sr_nx, op_q, tx, load_byte, mem_q, stat;
  logic [AW-9:0] addr_hi;
  logic          addr_hi_done, load_pend, got_byte;
  logic [AW-1:0] cur_addr;
  logic [PW-1:0] woff;
  logic          wel_q, bp0_q, bp1_q, wpen_q;
  logic          nw_wpen, nw_bp1, nw_bp0;
  logic          so_q, so_oe_q, wr_ok;

  spimem_array #(.DEPTH(DEPTH), .DW(8)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(cur_addr), .rdata(mem_q)
  );

  always_comb begin
    stat = 8'h00;
    stat[ST_WIP]  = wip;
    stat[ST_WEL]  = wel_q;
    stat[ST_BP0]  = bp0_q;
    stat[ST_BP1]  = bp1_q;
    stat[ST_WPEN] = wpen_q;
    sr_nx = {sr[6:0], si_s};
    wr_ok = wel_q && !wip;
    if (ph == PH_SRD) load_byte = stat;
    else if (wip)     load_byte = 8'hFF;
    else              load_byte = mem_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_CMD; bcnt <= '0; sr <= '0; op_q <= '0; tx <= '0;
      addr_hi <= '0; addr_hi_done <= 1'b0; load_pend <= 1'b0; got_byte <= 1'b0;
      cur_addr <= '0; woff <= '0; wel_q <= 1'b0; bp0_q <= 1'b0; bp1_q <= 1'b0;
      wpen_q <= 1'b0; nw_wpen <= 1'b0; nw_bp1 <= 1'b0; nw_bp0 <= 1'b0;
      so_q <= 1'b0; wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_commit <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (wip_fall) wel_q <= 1'b0;
      if (cs_s) begin
        if (cs_rise && bcnt == 3'd0) begin
          if (ph == PH_DONE) begin
            if (op_q == OP_WREN) wel_q <= 1'b1;
            else if (op_q == OP_WRDI) wel_q <= 1'b0;
            else if (op_q == OP_WRSR && wr_ok && !(wpen_q && !wp_s)) begin
              wpen_q <= nw_wpen; bp1_q <= nw_bp1; bp0_q <= nw_bp0;
              wel_q  <= 1'b0;
            end
          end else if (ph == PH_WDAT && got_byte && wr_ok) begin
            wr_commit <= 1'b1;
          end
        end
        ph <= PH_CMD; bcnt <= '0; load_pend <= 1'b0; got_byte <= 1'b0;
      end else if (sample) begin
        sr   <= sr_nx;
        bcnt <= bcnt + 3'd1;
        if (ph == PH_DONE) begin
          ph <= PH_SKIP;
        end else if (bcnt == 3'd7) begin
          unique case (ph)
            PH_CMD: begin
              op_q <= sr_nx;
              if (sr_nx == OP_READ || sr_nx == OP_WRITE) begin
                ph <= PH_ADDR; addr_hi_done <= 1'b0;
              end else if (sr_nx == OP_RDSR) begin
                ph <= PH_SRD; load_pend <= 1'b1;
              end else if (sr_nx == OP_WRSR) ph <= PH_SWR;
              else if (sr_nx == OP_WREN || sr_nx == OP_WRDI) ph <= PH_DONE;
              else ph <= PH_SKIP;
            end
            PH_ADDR: begin
              if (!addr_hi_done) begin
                addr_hi <= sr_nx[AW-9:0]; addr_hi_done <= 1'b1;
              end else begin
                cur_addr <= {addr_hi, sr_nx};
                woff     <= sr_nx[PW-1:0];
                if (op_q == OP_READ) begin
                  ph <= PH_RDAT; load_pend <= 1'b1;
                end else ph <= PH_WDAT;
              end
            end
            PH_RDAT, PH_SRD: load_pend <= 1'b1;
            PH_WDAT: if (wr_ok) begin
              wr_valid <= 1'b1;
              wr_addr  <= {cur_addr[AW-1:PW], woff};
              wr_data  <= sr_nx;
              woff     <= woff + 1'b1;
              got_byte <= 1'b1;
            end
            PH_SWR: begin
              nw_wpen <= sr_nx[ST_WPEN]; nw_bp1 <= sr_nx[ST_BP1]; nw_bp0 <= sr_nx[ST_BP0];
              ph <= PH_DONE;
            end
            default: ;
          endcase
        end
      end else if (shift && (ph == PH_RDAT || ph == PH_SRD)) begin
        if (load_pend) begin
          so_q <= load_byte[7];
          tx   <= {load_byte[6:0], 1'b0};
          load_pend <= 1'b0;
          if (ph == PH_RDAT) cur_addr <= cur_addr + 1'b1;
        end else begin
          so_q <= tx[7];
          tx   <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) so_oe_q <= 1'b0;
    else     so_oe_q <= active && (ph == PH_RDAT || ph == PH_SRD);
  end

  assign so    = so_q;
  assign so_oe = so_oe_q;

  assert_oe_cs_R12: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !so_oe);
  assert_oe_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !hold_s |=> !so_oe);
  assert_idle_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(!wip));
  assert_event_excl_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_valid, wr_commit}));
  assert_skip_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_SKIP) |-> (!so_oe && !wr_valid && !wr_commit));
endmodule

// File: tb/sim_spimem_slave.sv
`timescale 1ns/1ps
module sim_spimem_slave;
  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1, wip = 1'b0;
  logic arr_we = 1'b0;
  logic [9:0] arr_waddr = '0;
  logic [7:0] arr_wdata = '0;
  logic so, so_oe, wr_valid, wr_commit;
  logic [9:0] wr_addr;
  logic [7:0] wr_data;

  always #2.5 clk = ~clk;

  spimem_slave u0 (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .so(so), .so_oe(so_oe), .wip(wip), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] em [1024];
  logic [9:0] ev_a [64];
  logic [7:0] ev_d [64];
  int ev_n = 0, cm_n = 0;
  logic oe_any;

  always @(posedge clk) begin
    if (wr_valid && ev_n < 64) begin
      ev_a[ev_n] <= wr_addr; ev_d[ev_n] <= wr_data; ev_n <= ev_n + 1;
    end
    if (wr_commit) cm_n <= cm_n + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ {6'h15, 2'(a >> 8)};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input int k);
    return em[(int'(a) + k) & 1023];
  endfunction

  task automatic bitx(input logic b, output logic o);
    o = so;
    oe_any |= so_oe;
    si = b; waitn(4);
    sck = 1'b1; waitn(8);
    sck = 1'b0; waitn(8);
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bitx(d[i], r[i]);
  endtask

  task automatic cs_lo(); cs_n = 1'b0; waitn(6); endtask
  task automatic cs_hi(); cs_n = 1'b1; waitn(8); endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); xbyte(op, r); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    cs_lo(); xbyte(8'h05, r); xbyte(8'h00, s); cs_hi();
  endtask

  task automatic do_read(input string tag, input logic [15:0] a, input int n);
    logic [7:0] r;
    cs_lo();
    xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, r);
      check(tag, r, exp_rd(a, k));
    end
    cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    cs_lo(); xbyte(8'h01, r); xbyte(v, r); cs_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s, r;
    logic [15:0] a;
    int e0, c0, n;
    void'($urandom(32'd4711));
    waitn(4); rst = 1'b0; waitn(4);
    // R13: reset state
    check("R13 so_oe", so_oe, 0);
    check("R13 wr_valid", wr_valid, 0);
    for (int i = 0; i < 1024; i++) begin
      arr_we = 1'b1; arr_waddr = 10'(i); arr_wdata = pat(i); em[i] = pat(i);
      waitn(1);
    end
    arr_we = 1'b0; waitn(2);
    rdsr(s); check("R13 status", s, 8'h00);
    check("R12 idle oe", so_oe, 0);

    // R1 R2 R3: read across top of the array with don't-care bits set
    do_read("R3 wrap", 16'hFC00 | 16'h3FE, 4);
    cs_lo(); xbyte(8'h03, r); xbyte(8'h01, r); xbyte(8'h23, r); xbyte(8'h00, r);
    check("R1 msb first", r, em[10'h123]);
    check("R2 oe during read", so_oe, 1);
    cs_hi();
    check("R12 oe after cs", so_oe, 0);

    // R2: random reads
    for (int t = 0; t < 20; t++) begin
      a = 16'($urandom);
      if (t % 5 == 0) a[9:0] = 10'h3FF;
      n = 1 + int'($urandom % 3);
      do_read("R2 random", a, n);
    end

    // R5: latch rules
    cs_lo(); xbyte(8'h06, r); xbyte(8'h00, r); cs_hi();
    rdsr(s); check("R5 wren extra bits", s, 8'h00);
    cmd(8'h06); rdsr(s); check("R5 wren", s, 8'h02);
    cmd(8'h04); rdsr(s); check("R5 wrdi", s, 8'h00);

    // R7: write without latch
    e0 = ev_n; c0 = cm_n;
    cs_lo(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h20, r);
    xbyte(8'h11, r); xbyte(8'h22, r); cs_hi();
    check("R7 no events unlatched", ev_n - e0, 0);
    check("R7 no commit unlatched", cm_n - c0, 0);

    // R6 R7: page wrap write
    cmd(8'h06);
    e0 = ev_n; c0 = cm_n;
    cs_lo(); xbyte(8'h02, r); xbyte(8'hF8, r); xbyte(8'h1E, r);
    xbyte(8'hA1, r); xbyte(8'hB2, r); xbyte(8'hC3, r); xbyte(8'hD4, r); cs_hi();
    check("R6 event count", ev_n - e0, 4);
    check("R7 commit", cm_n - c0, 1);
    check("R6 addr0", ev_a[e0], 10'h01E);
    check("R6 addr1", ev_a[e0+1], 10'h01F);
    check("R6 addr2 page wrap", ev_a[e0+2], 10'h010);
    check("R6 addr3", ev_a[e0+3], 10'h011);
    check("R6 data2", ev_d[e0+2], 8'hC3);
    wip = 1'b1;
    for (int k = 0; k < 4; k++) begin
      arr_we = 1'b1; arr_waddr = ev_a[e0+k]; arr_wdata = ev_d[e0+k];
      em[ev_a[e0+k]] = ev_d[e0+k]; waitn(1);
    end
    arr_we = 1'b0;
    rdsr(s); check("R4 busy status", s, 8'h03);
    cs_lo(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h10, r); xbyte(8'h00, r);
    check("R10 busy read", r, 8'hFF);
    cs_hi();
    wip = 1'b0; waitn(4);
    rdsr(s); check("R5 latch clears after busy", s, 8'h00);
    do_read("R6 written data", 16'h0010, 2);

    // R7: transfer ending mid-byte
    cmd(8'h06);
    e0 = ev_n; c0 = cm_n;
    cs_lo(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h40, r); xbyte(8'h5A, r);
    for (int i = 0; i < 3; i++) bitx(1'b1, r[0]);
    cs_hi();
    check("R7 partial event", ev_n - e0, 1);
    check("R7 partial no commit", cm_n - c0, 0);
    cmd(8'h04);

    // R8: status write and protection
    cmd(8'h06); wrsr(8'hFF);
    rdsr(s); check("R8 status write", s, 8'h8C);
    wp_n = 1'b0; cmd(8'h06); wrsr(8'h00);
    rdsr(s); check("R8 protected", s, 8'h8E);
    wp_n = 1'b1; wrsr(8'h00);
    rdsr(s); check("R8 unprotected", s, 8'h00);

    // R4: continuous status read
    cmd(8'h06);
    cs_lo(); xbyte(8'h05, r); xbyte(8'h00, s); xbyte(8'h00, r); cs_hi();
    check("R4 status repeat", r, 8'h02);
    check("R4 status first", s, 8'h02);
    cmd(8'h04);

    // R9: pause in the middle of a read byte
    cs_lo(); xbyte(8'h03, r); xbyte(8'h01, r); xbyte(8'h55, r);
    for (int i = 7; i >= 0; i--) begin
      if (i == 3) begin
        hold_n = 1'b0; waitn(6);
        check("R9 oe in pause", so_oe, 0);
        for (int j = 0; j < 3; j++) begin
          si = 1'b1; sck = 1'b1; waitn(8); sck = 1'b0; waitn(8);
        end
        hold_n = 1'b1; waitn(6);
      end
      bitx(1'b0, r[i]);
    end
    check("R9 byte after pause", r, em[10'h155]);
    xbyte(8'h00, r);
    check("R9 next byte", r, em[10'h156]);
    cs_hi();

    // R11: unknown command
    e0 = ev_n; oe_any = 1'b0;
    cs_lo(); xbyte(8'hA5, r); xbyte(8'h00, r); xbyte(8'hFF, r); cs_hi();
    check("R11 oe quiet", oe_any, 0);
    check("R11 no events", ev_n - e0, 0);
    rdsr(s); check("R11 status kept", s, 8'h00);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule